// File: doc/BRIEF.md
# PHY configuration strap controller

This block turns the configuration strap pins of an Ethernet PHY into the values of the management register bits they govern. It is built around a small sequencer. While reset is held, every mapped bit is zero. At the first clock after reset is released, every strap is captured. From then on, one group of straps is frozen. A second group keeps driving its bits live, but only while the manual-control input is high.

The live group needs more care. Its pins pass through a multi-stage synchronizer. Two of those pins are watched over time:
- A rising edge on the restart pin produces a one-cycle auto-negotiation restart pulse.
- Any change on the decoded crossover code produces a one-cycle internal reset pulse.

The duplex strap maps in one of two ways, chosen by the auto-negotiation enable input. When auto-negotiation is on, it feeds the full-duplex advertisement bits, each gated by its speed strap. When auto-negotiation is off, it forces the duplex control bit. A test-clock mode input removes the duplex and pause meanings altogether.

The sequencer has three states:

| State | What it does | Leaves when |
|-------|--------------|-------------|
| `ST_RESET` | Held while reset is asserted; all captured state is zero. | The first clock after release captures all straps and moves to `ST_SETTLE`. |
| `ST_SETTLE` | Waits until the synchronizer holds post-reset pin values. | The settle count ends (one cycle with the default two stages); it then moves to `ST_RUN`. |
| `ST_RUN` | Does live tracking and edge/change detection. | Only asserting reset returns the sequencer to `ST_RESET`. |

Top module: `phy_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: The frozen straps (smart-speed, isolate, serial-10, ten-bit) appear on `ext_smart`, `ext_isolate`, `ext_serial10` and `ext_tenbit`. They are captured at the first clock edge after `rst_n` rises. Later pin changes have no effect until the next reset.
- R3: The live straps are duplex, pause, master, speed[2:0] and crossover[1:0].
  - With `manual_mode` = 0, their mapped bits keep the values captured at reset release.
  - With `manual_mode` = 1, the mapped bits follow the pins. A pin change is visible after the second rising clock edge that follows it.
- R4: With `an_enable` = 1 and `test_clk_mode` = 0, each advertisement bit equals duplex AND its speed strap:
  - `adv_fd_1000` uses speed[2];
  - `adv_fd_100` uses speed[1];
  - `adv_fd_10` uses speed[0].
  In this mode `reg_full_duplex` = 0.
- R5: With `an_enable` = 0 and `test_clk_mode` = 0, `reg_full_duplex` equals the duplex strap (1 = full, 0 = half), and all three advertisement bits are 0.
- R6: With `test_clk_mode` = 0, `adv_pause` and `adv_asym_dir` both equal the pause strap.
- R7: With `test_clk_mode` = 1, `reg_full_duplex`, the three advertisement bits, `adv_pause` and `adv_asym_dir` are all 0.
- R8: `port_master` equals the master strap (1 = master).
- R9: A restart pulse needs all of the following: a rising edge on `pin_restart`, `manual_mode` = 1, `an_enable` = 1, and the sequencer in `ST_RUN`. The pulse is `reg_restart_an` high for exactly one cycle, starting at the third rising edge after the pin change. A falling edge gives no pulse, and `an_enable` = 0 gives no pulse.
- R10: A change on `pin_xover` while `manual_mode` = 1 and the sequencer is in `ST_RUN` drives `int_reset` high for exactly one cycle, starting at the third rising edge after the change. A change while `manual_mode` = 0 gives no pulse. `xover_mode` carries the effective crossover code (00 = NIC, 01 = switch, 10 = automatic).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, released synchronously; its rising edge triggers strap capture |
| an_enable | input | 1 | Auto-negotiation enable from the control register |
| manual_mode | input | 1 | Manual-control mode: live straps keep driving their bits |
| test_clk_mode | input | 1 | Duplex/pause pins serve as test-clock outputs |
| pin_duplex | input | 1 | Duplex strap |
| pin_pause | input | 1 | Pause strap |
| pin_master | input | 1 | Master/slave strap |
| pin_restart | input | 1 | Auto-negotiation restart strap |
| pin_speed | input | 3 | Speed straps: [2] 1000, [1] 100, [0] 10 |
| pin_xover | input | 2 | Decoded crossover code |
| pin_smart | input | 1 | Smart-speed strap (frozen at reset) |
| pin_isolate | input | 1 | Negotiation isolate strap (frozen at reset) |
| pin_serial10 | input | 1 | Serial 10 Mb/s strap (frozen at reset) |
| pin_tenbit | input | 1 | Ten-bit interface strap (frozen at reset) |
| reg_restart_an | output | 1 | Restart bit, self-clearing one-cycle pulse |
| reg_full_duplex | output | 1 | Forced duplex control bit |
| adv_fd_1000 | output | 1 | 1000 full-duplex advertisement |
| adv_fd_100 | output | 1 | 100 full-duplex advertisement |
| adv_fd_10 | output | 1 | 10 full-duplex advertisement |
| adv_pause | output | 1 | Pause advertisement |
| adv_asym_dir | output | 1 | Asymmetric pause advertisement |
| port_master | output | 1 | Master/slave port type bit |
| ext_smart | output | 1 | Smart-speed enable bit |
| ext_isolate | output | 1 | Negotiation isolate bit |
| ext_serial10 | output | 1 | Serial 10 Mb/s mode bit |
| ext_tenbit | output | 1 | Ten-bit interface mode bit |
| xover_mode | output | 2 | Effective crossover code |
| int_reset | output | 1 | Internal reset pulse |

## Verification
The results of this block arrive at different times after a stimulus:
- The frozen bits appear one edge after reset release.
- A live pin change reaches its mapped bit after two rising edges, because of the synchronizer.
- The restart and internal-reset pulses need one more register, so they are high only in the cycle that begins at the third edge.
- The mode inputs act on the outputs combinationally, in the same cycle.

The bench drives inputs on falling edges and samples on falling edges, with exactly those edge counts. For pulses, it also checks the cycle before and the cycle after, so that a pulse one cycle early, one cycle late or too wide is caught. Where a requirement says a pulse must not appear, the bench watches the pulse output over a window longer than the full latency.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {ST_RESET, ST_SETTLE, ST_RUN} seq_state_t;

    // Live straps: tracked while manual mode is on
    typedef struct packed {
        logic [1:0] xover;
        logic [2:0] speed;   // [2] 1000, [1] 100, [0] 10
        logic       restart;
        logic       master;
        logic       pause;
        logic       duplex;
    } live_straps_t;

    // Frozen straps: captured once at reset release
    typedef struct packed {
        logic tenbit;
        logic serial10;
        logic isolate;
        logic smart;
    } fixed_straps_t;

    localparam int LIVE_W = $bits(live_straps_t);
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          manual_mode,
    input  logic          an_enable,
    input  live_straps_t  raw_live,
    input  fixed_straps_t raw_fixed,
    input  live_straps_t  sync_live,
    output live_straps_t  eff_live,
    output fixed_straps_t fixed_q,
    output logic          restart_pulse,
    output logic          xreset_pulse
);
    localparam int SETTLE_CYC = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;
    localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

    seq_state_t    state, state_nxt;
    logic [CNT_W-1:0] settle_cnt;
    live_straps_t  cap_live;
    fixed_straps_t cap_fixed;
    logic          prev_restart;
    logic [1:0]    prev_xover;
    logic          running, rise_seen, xover_moved;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET:  state_nxt = ST_SETTLE;
            ST_SETTLE: if (settle_cnt == CNT_W'(SETTLE_CYC - 1)) state_nxt = ST_RUN;
            ST_RUN:    state_nxt = ST_RUN;
            default:   state_nxt = ST_RESET;
        endcase
    end

    assign running     = (state == ST_RUN);
    assign rise_seen   = running && sync_live.restart && !prev_restart;
    assign xover_moved = running && (sync_live.xover != prev_xover);

    // Capture, tracking and pulse registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt    <= '0;
            cap_live      <= '0;
            cap_fixed     <= '0;
            prev_restart  <= 1'b0;
            prev_xover    <= 2'b00;
            restart_pulse <= 1'b0;
            xreset_pulse  <= 1'b0;
        end else begin
            restart_pulse <= rise_seen && manual_mode && an_enable;
            xreset_pulse  <= xover_moved && manual_mode;
            unique case (state)
                ST_RESET: begin
                    cap_live     <= raw_live;
                    cap_fixed    <= raw_fixed;
                    prev_restart <= raw_live.restart;
                    prev_xover   <= raw_live.xover;
                    settle_cnt   <= '0;
                end
                ST_SETTLE: settle_cnt <= settle_cnt + 1'b1;
                ST_RUN: begin
                    prev_restart <= sync_live.restart;
                    prev_xover   <= sync_live.xover;
                end
                default: settle_cnt <= '0;
            endcase
        end
    end

    assign eff_live = (running && manual_mode) ? sync_live : cap_live;
    assign fixed_q  = cap_fixed;

    assert_latch_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(cap_fixed));
    assert_restart_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);
    assert_restart_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_pulse) |-> $past(an_enable) && $past(manual_mode));
    assert_xreset_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xreset_pulse |=> !xreset_pulse);
    assert_xreset_manual_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xreset_pulse) |-> $past(manual_mode));
endmodule

// File: rtl/strap_map.sv
module strap_map
    import strap_pkg::*;
(
    input  live_straps_t  eff_live,
    input  fixed_straps_t fixed_q,
    input  logic          an_enable,
    input  logic          test_clk_mode,
    output logic          full_duplex,
    output logic [2:0]    adv_fd,
    output logic          adv_pause,
    output logic          adv_asym,
    output logic          master,
    output logic [3:0]    ext_bits
);
    logic strap_fn;
    assign strap_fn = !test_clk_mode;

    always_comb begin
        full_duplex = strap_fn && !an_enable && eff_live.duplex;
        adv_fd      = (strap_fn && an_enable && eff_live.duplex) ? eff_live.speed : 3'b000;
        adv_pause   = strap_fn && eff_live.pause;
        adv_asym    = strap_fn && eff_live.pause;
        master      = eff_live.master;
        ext_bits    = fixed_q;
    end
endmodule

// File: rtl/phy_strap_ctrl.sv
module phy_strap_ctrl
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       an_enable,
    input  logic       manual_mode,
    input  logic       test_clk_mode,
    input  logic       pin_duplex,
    input  logic       pin_pause,
    input  logic       pin_master,
    input  logic       pin_restart,
    input  logic [2:0] pin_speed,
    input  logic [1:0] pin_xover,
    input  logic       pin_smart,
    input  logic       pin_isolate,
    input  logic       pin_serial10,
    input  logic       pin_tenbit,
    output logic       reg_restart_an,
    output logic       reg_full_duplex,
    output logic       adv_fd_1000,
    output logic       adv_fd_100,
    output logic       adv_fd_10,
    output logic       adv_pause,
    output logic       adv_asym_dir,
    output logic       port_master,
    output logic       ext_smart,
    output logic       ext_isolate,
    output logic       ext_serial10,
    output logic       ext_tenbit,
    output logic [1:0] xover_mode,
    output logic       int_reset
);
    live_straps_t  raw_live, sync_live, eff_live;
    fixed_straps_t raw_fixed, fixed_q;
    logic [LIVE_W-1:0] sync_vec;
    logic [2:0] adv_fd;
    logic [3:0] ext_bits;

    assign raw_live  = '{xover: pin_xover, speed: pin_speed, restart: pin_restart,
                         master: pin_master, pause: pin_pause, duplex: pin_duplex};
    assign raw_fixed = '{tenbit: pin_tenbit, serial10: pin_serial10,
                         isolate: pin_isolate, smart: pin_smart};

    strap_sync #(.WIDTH(LIVE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_live), .q(sync_vec)
    );
    assign sync_live = live_straps_t'(sync_vec);

    strap_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk(clk), .rst_n(rst_n), .manual_mode(manual_mode), .an_enable(an_enable),
        .raw_live(raw_live), .raw_fixed(raw_fixed), .sync_live(sync_live),
        .eff_live(eff_live), .fixed_q(fixed_q),
        .restart_pulse(reg_restart_an), .xreset_pulse(int_reset)
    );

    strap_map u_map (
        .eff_live(eff_live), .fixed_q(fixed_q), .an_enable(an_enable),
        .test_clk_mode(test_clk_mode), .full_duplex(reg_full_duplex), .adv_fd(adv_fd),
        .adv_pause(adv_pause), .adv_asym(adv_asym_dir), .master(port_master),
        .ext_bits(ext_bits)
    );

    assign {adv_fd_1000, adv_fd_100, adv_fd_10} = adv_fd;
    assign {ext_tenbit, ext_serial10, ext_isolate, ext_smart} = ext_bits;
    assign xover_mode = eff_live.xover;
endmodule

// File: tb/phy_strap_ctrl_tb.sv
module phy_strap_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, an_enable, manual_mode, test_clk_mode;
    logic pin_duplex, pin_pause, pin_master, pin_restart;
    logic [2:0] pin_speed;
    logic [1:0] pin_xover;
    logic pin_smart, pin_isolate, pin_serial10, pin_tenbit;
    logic reg_restart_an, reg_full_duplex, adv_fd_1000, adv_fd_100, adv_fd_10;
    logic adv_pause, adv_asym_dir, port_master;
    logic ext_smart, ext_isolate, ext_serial10, ext_tenbit, int_reset;
    logic [1:0] xover_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_strap_ctrl u_dut (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic dup, input logic pau, input logic mas,
                            input logic [2:0] spd, input logic [1:0] xo, input logic [3:0] fixed);
        pin_duplex = dup; pin_pause = pau; pin_master = mas; pin_speed = spd;
        pin_xover = xo; {pin_tenbit, pin_serial10, pin_isolate, pin_smart} = fixed;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(4);
    endtask

    task automatic test_reset_r1();
        an_enable = 0; manual_mode = 1; test_clk_mode = 0; pin_restart = 1;
        set_pins(1, 1, 1, 3'b111, 2'b01, 4'hF);
        rst_n = 1'b0;
        step(3);
        chk("R1 outputs in reset",
            {reg_restart_an, reg_full_duplex, adv_fd_1000, adv_fd_100, adv_fd_10, adv_pause,
             adv_asym_dir, port_master, ext_smart, ext_isolate, ext_serial10, ext_tenbit,
             xover_mode, int_reset}, 16'h0);
        pin_restart = 0;
    endtask

    task automatic test_latch_r2();
        manual_mode = 1; set_pins(0, 0, 0, 3'b000, 2'b00, 4'b0101);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        chk("R2 capture at first edge", {ext_tenbit, ext_serial10, ext_isolate, ext_smart}, 4'b0101);
        {pin_tenbit, pin_serial10, pin_isolate, pin_smart} = 4'b1010;
        step(6);
        chk("R2 later changes ignored", {ext_tenbit, ext_serial10, ext_isolate, ext_smart}, 4'b0101);
    endtask

    task automatic test_manual_r3();
        manual_mode = 0; set_pins(0, 0, 1, 3'b000, 2'b00, 4'h0);
        do_reset();
        pin_master = 0; step(4);
        chk("R3 hold captured when manual off", port_master, 1'b1);
        manual_mode = 1; step(1);
        chk("R3 live value when manual on", port_master, 1'b0);
        pin_master = 1; step(1);
        chk("R3 not yet after one edge", port_master, 1'b0);
        step(1);
        chk("R3 tracked after two edges R8", port_master, 1'b1);
    endtask

    task automatic test_an_r4();
        manual_mode = 1; an_enable = 1; test_clk_mode = 0;
        pin_duplex = 1; pin_speed = 3'b101; step(2);
        chk("R4 adv fd speed 101", {adv_fd_1000, adv_fd_100, adv_fd_10, reg_full_duplex}, 4'b1010);
        pin_speed = 3'b010; step(2);
        chk("R4 adv fd speed 010", {adv_fd_1000, adv_fd_100, adv_fd_10, reg_full_duplex}, 4'b0100);
        pin_duplex = 0; step(2);
        chk("R4 duplex low no adv", {adv_fd_1000, adv_fd_100, adv_fd_10}, 3'b000);
    endtask

    task automatic test_forced_r5();
        an_enable = 0; pin_duplex = 1; pin_speed = 3'b111; step(2);
        chk("R5 forced full", {reg_full_duplex, adv_fd_1000, adv_fd_100, adv_fd_10}, 4'b1000);
        pin_duplex = 0; step(2);
        chk("R5 forced half", reg_full_duplex, 1'b0);
    endtask

    task automatic test_pause_r6();
        pin_pause = 1; step(2);
        chk("R6 pause high", {adv_pause, adv_asym_dir}, 2'b11);
        pin_pause = 0; step(2);
        chk("R6 pause low", {adv_pause, adv_asym_dir}, 2'b00);
    endtask

    task automatic test_tclk_r7();
        pin_pause = 1; pin_duplex = 1; pin_speed = 3'b111; an_enable = 0; step(2);
        test_clk_mode = 1; step(1);
        chk("R7 forced duplex off", {reg_full_duplex, adv_pause, adv_asym_dir}, 3'b000);
        an_enable = 1; step(1);
        chk("R7 adv off", {adv_fd_1000, adv_fd_100, adv_fd_10, adv_pause}, 4'b0000);
        test_clk_mode = 0; step(1);
        chk("R7 restored", {adv_fd_1000, adv_fd_100, adv_fd_10, adv_pause}, 4'b1111);
    endtask

    task automatic test_restart_r9();
        int cnt;
        manual_mode = 1; an_enable = 1; pin_restart = 0; step(4);
        pin_restart = 1; step(2);
        chk("R9 not early", reg_restart_an, 1'b0);
        step(1);
        chk("R9 pulse at third edge", reg_restart_an, 1'b1);
        step(1);
        chk("R9 self-clear", reg_restart_an, 1'b0);
        cnt = 0; pin_restart = 0;
        for (int i = 0; i < 6; i++) begin step(1); cnt += reg_restart_an; end
        chk("R9 falling edge no pulse", cnt[15:0], 16'd0);
        an_enable = 0; cnt = 0; pin_restart = 1;
        for (int i = 0; i < 6; i++) begin step(1); cnt += reg_restart_an; end
        chk("R9 no pulse when AN off", cnt[15:0], 16'd0);
        pin_restart = 0; an_enable = 1; step(4);
    endtask

    task automatic test_xover_r10();
        int cnt;
        manual_mode = 1; set_pins(0, 0, 0, 3'b000, 2'b00, 4'h0);
        do_reset();
        pin_xover = 2'b01; step(2);
        chk("R10 not early", int_reset, 1'b0);
        chk("R10 mode follows", xover_mode, 2'b01);
        step(1);
        chk("R10 pulse at third edge", int_reset, 1'b1);
        step(1);
        chk("R10 single cycle", int_reset, 1'b0);
        manual_mode = 0; cnt = 0; pin_xover = 2'b10;
        for (int i = 0; i < 6; i++) begin step(1); cnt += int_reset; end
        chk("R10 no pulse manual off", cnt[15:0], 16'd0);
        chk("R10 captured code manual off", xover_mode, 2'b00);
    endtask

    initial begin
        step(150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset_r1();
        test_latch_r2();
        test_manual_r3();
        test_an_r4();
        test_forced_r5();
        test_pause_r6();
        test_tclk_r7();
        test_restart_r9();
        test_xover_r10();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule